// File: doc/BRIEF.md
# Triple-Bank Rotating Segment Buffer

This block holds three consecutive part-program segments for a path-generation processor in three separate 256 x 16-bit RAM banks. Each bank plays one of three roles at a time: the interpolation bank (the segment being executed), the compensation bank (the next segment, being tool-corrected) and the refill bank (the segment after that, being loaded). The local processor reaches the interpolation and compensation banks through two dedicated ports. External bus masters reach only the refill bank, always through the same bus port and the same addresses, whichever physical bank that happens to be.

A 3-bit one-hot ring register decides which physical bank plays which role. When the local processor signals that the current segment is finished, the ring rotates: the compensation bank becomes the interpolation bank, the refill bank becomes the compensation bank, and the bank that was just interpolated becomes the refill bank. A refill interrupt is raised at the same moment and stays pending until the coordinating master acknowledges it. At start-up the coordinating master loads the ring directly.

The bus port serves both 16-bit masters (full words) and 8-bit masters. An 8-bit master moves each word as two byte transfers on the low data lanes; for the high byte the block swaps the lanes so that the high byte of the stored word travels on bits 7:0.

Top module: `seg_ring_buffer`

## Requirements
- R1: After reset ring_o is 3'b001, refill_irq_o is 0 and overrun_o is 0.
- R2: With ring_o bit i set, bank i is the interpolation bank, bank (i+1) mod 3 the compensation bank and bank (i+2) mod 3 the refill bank; the int port reaches only the interpolation bank, the cmp port only the compensation bank and the bus port only the refill bank.
- R3: A write is stored at the clock edge where the request is sampled; read data appears on the port's rdata output one clock after the request is sampled and stays until the next read on that port.
- R4: A seg_done_i pulse without ring_load_i rotates the ring one place up: 001 becomes 010, 010 becomes 100, 100 becomes 001.
- R5: Each rotation sets refill_irq_o in the next cycle; it stays 1 until irq_ack_i is sampled in a cycle with no rotation, which clears it; a rotation in the same cycle as an acknowledge leaves it set.
- R6: A rotation while refill_irq_o is 1 and irq_ack_i is 0 sets overrun_o; overrun_o stays 1 until irq_ack_i is sampled.
- R7: ring_load_i with a one-hot ring_val_i loads that value, takes priority over seg_done_i in the same cycle, and changes neither refill_irq_o nor overrun_o.
- R8: ring_load_i with a ring_val_i that is not one-hot loads 3'b001.
- R9: On a bus write with bus_byte_i=1, bus_wdata_i[7:0] is written to the low byte of the word when bus_hi_i=0 and to the high byte when bus_hi_i=1; the other byte keeps its value. With bus_byte_i=0 the whole 16-bit word is written.
- R10: On a bus read with bus_byte_i=1, bus_rdata_o[7:0] carries the low byte (bus_hi_i=0) or the high byte (bus_hi_i=1) of the word and bus_rdata_o[15:8] is 0; with bus_byte_i=0 the whole word is returned.
- R11: Bank contents are untouched by rotation: a word loaded into the refill bank is read unchanged through the cmp port after one rotation and through the int port after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| int_req_i | input | 1 | Interpolation port access request |
| int_we_i | input | 1 | Interpolation port write enable |
| int_addr_i | input | 8 | Interpolation port word address |
| int_wdata_i | input | 16 | Interpolation port write data |
| int_rdata_o | output | 16 | Interpolation port read data |
| cmp_req_i | input | 1 | Compensation port access request |
| cmp_we_i | input | 1 | Compensation port write enable |
| cmp_addr_i | input | 8 | Compensation port word address |
| cmp_wdata_i | input | 16 | Compensation port write data |
| cmp_rdata_o | output | 16 | Compensation port read data |
| bus_req_i | input | 1 | Bus access request to the refill bank |
| bus_we_i | input | 1 | Bus write enable |
| bus_byte_i | input | 1 | 1: 8-bit master byte transfer, 0: full word |
| bus_hi_i | input | 1 | Byte transfer selects the high byte (swapped onto low lanes) |
| bus_addr_i | input | 8 | Bus word address |
| bus_wdata_i | input | 16 | Bus write data |
| bus_rdata_o | output | 16 | Bus read data |
| ring_load_i | input | 1 | Coordinator loads the ring register |
| ring_val_i | input | 3 | Value for a ring load |
| seg_done_i | input | 1 | Local processor finished the current segment |
| irq_ack_i | input | 1 | Coordinator acknowledges the refill interrupt |
| ring_o | output | 3 | Current ring register (interpolation bank one-hot) |
| refill_irq_o | output | 1 | Refill interrupt pending |
| overrun_o | output | 1 | Rotation happened while refill was still pending |

## Verification
The bench follows one word loaded through the bus port across two rotations until it surfaces on the interpolation port; a design that swapped the compensation and refill roles or rotated the wrong way would return another bank's data there. It rotates twice without acknowledging to provoke an overrun, and rotates in the same cycle as an acknowledge, where a design giving the clear priority would drop a pending interrupt. It loads the ring together with seg_done and with non-one-hot values, catching a design that lets the rotation win or keeps an illegal pattern. Byte transfers of both halves, plus a low-byte rewrite, expose a swap path that clobbers the other byte or returns the high byte on the wrong lanes.

// File: rtl/seg_buf_pkg.sv
package seg_buf_pkg;
  localparam int RING_W = 3;
  localparam logic [RING_W-1:0] RING_RST = 3'b001;

  function automatic logic is_onehot3(input logic [RING_W-1:0] v);
    return (v == 3'b001) || (v == 3'b010) || (v == 3'b100);
  endfunction

  function automatic logic [RING_W-1:0] ring_next(input logic [RING_W-1:0] v);
    return {v[RING_W-2:0], v[RING_W-1]};
  endfunction
endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                en_i,
  input  logic                we_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NB    = DATA_W / 8;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk_i) begin
      if (en_i && we_i && be_i[g]) mem_q[addr_i][g*8 +: 8] <= wdata_i[g*8 +: 8];
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_i && !we_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/seg_role_ring.sv
module seg_role_ring
  import seg_buf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [RING_W-1:0] load_val_i,
  input  logic              advance_i,
  input  logic              ack_i,
  output logic [RING_W-1:0] ring_o,
  output logic              irq_o,
  output logic              overrun_o
);
  logic [RING_W-1:0] ring_q, ring_d;
  logic irq_q, ovr_q;
  logic rotate;

  assign rotate = advance_i && !load_i;

  always_comb begin
    ring_d = ring_q;
    if (load_i)      ring_d = is_onehot3(load_val_i) ? load_val_i : RING_RST;
    else if (rotate) ring_d = ring_next(ring_q);
    // recover from any corrupted pattern
    if (!is_onehot3(ring_d)) ring_d = RING_RST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q <= RING_RST;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      ring_q <= ring_d;
      if (rotate)     irq_q <= 1'b1;
      else if (ack_i) irq_q <= 1'b0;
      if (rotate && irq_q && !ack_i) ovr_q <= 1'b1;
      else if (ack_i)                ovr_q <= 1'b0;
    end
  end

  assign ring_o    = ring_q;
  assign irq_o     = irq_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/seg_bus_lane.sv
module seg_bus_lane #(
  parameter int DATA_W = 16
) (
  input  logic              byte_i,
  input  logic              hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [1:0]        be_o,
  input  logic              rd_byte_i,
  input  logic              rd_hi_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    if (byte_i) begin
      wdata_o = {wdata_i[HALF-1:0], wdata_i[HALF-1:0]};
      be_o    = hi_i ? 2'b10 : 2'b01;
    end else begin
      wdata_o = wdata_i;
      be_o    = 2'b11;
    end
  end

  always_comb begin
    if (!rd_byte_i)  rdata_o = word_i;
    else if (rd_hi_i) rdata_o = {{HALF{1'b0}}, word_i[DATA_W-1:HALF]};
    else             rdata_o = {{HALF{1'b0}}, word_i[HALF-1:0]};
  end
endmodule

// File: rtl/seg_ring_buffer.sv
module seg_ring_buffer
  import seg_buf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_req_i,
  input  logic              int_we_i,
  input  logic [ADDR_W-1:0] int_addr_i,
  input  logic [DATA_W-1:0] int_wdata_i,
  output logic [DATA_W-1:0] int_rdata_o,
  input  logic              cmp_req_i,
  input  logic              cmp_we_i,
  input  logic [ADDR_W-1:0] cmp_addr_i,
  input  logic [DATA_W-1:0] cmp_wdata_i,
  output logic [DATA_W-1:0] cmp_rdata_o,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic              bus_byte_i,
  input  logic              bus_hi_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              ring_load_i,
  input  logic [RING_W-1:0] ring_val_i,
  input  logic              seg_done_i,
  input  logic              irq_ack_i,
  output logic [RING_W-1:0] ring_o,
  output logic              refill_irq_o,
  output logic              overrun_o
);
  localparam int NB = DATA_W / 8;

  logic [RING_W-1:0] ring, int_map, cmp_map, fill_map;
  logic [RING_W-1:0] int_rd_q, cmp_rd_q, fill_rd_q;
  logic              bus_byte_q, bus_hi_q;
  logic [DATA_W-1:0] bus_wdata_sw, bus_word;
  logic [1:0]        bus_be;
  logic [DATA_W-1:0] bank_q [RING_W];

  seg_role_ring u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ring_load_i),
    .load_val_i (ring_val_i),
    .advance_i  (seg_done_i),
    .ack_i      (irq_ack_i),
    .ring_o     (ring),
    .irq_o      (refill_irq_o),
    .overrun_o  (overrun_o)
  );

  // bank b is compensation when ring[b-1], refill when ring[b+1]
  assign int_map  = ring;
  assign cmp_map  = {ring[1:0], ring[2]};
  assign fill_map = {ring[0], ring[2:1]};

  seg_bus_lane #(.DATA_W(DATA_W)) u_lane (
    .byte_i    (bus_byte_i),
    .hi_i      (bus_hi_i),
    .wdata_i   (bus_wdata_i),
    .wdata_o   (bus_wdata_sw),
    .be_o      (bus_be),
    .rd_byte_i (bus_byte_q),
    .rd_hi_i   (bus_hi_q),
    .word_i    (bus_word),
    .rdata_o   (bus_rdata_o)
  );

  for (genvar b = 0; b < RING_W; b++) begin : g_bank
    logic              en, we;
    logic [NB-1:0]     be;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;

    always_comb begin
      if (int_map[b]) begin
        en = int_req_i; we = int_we_i; be = '1;
        addr = int_addr_i; wdata = int_wdata_i;
      end else if (cmp_map[b]) begin
        en = cmp_req_i; we = cmp_we_i; be = '1;
        addr = cmp_addr_i; wdata = cmp_wdata_i;
      end else begin
        en = bus_req_i; we = bus_we_i; be = bus_be;
        addr = bus_addr_i; wdata = bus_wdata_sw;
      end
    end

    seg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk_i   (clk_i),
      .en_i    (en),
      .we_i    (we),
      .be_i    (be),
      .addr_i  (addr),
      .wdata_i (wdata),
      .rdata_o (bank_q[b])
    );
  end

  // remember which bank served each port's read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_rd_q   <= RING_RST;
      cmp_rd_q   <= ring_next(RING_RST);
      fill_rd_q  <= ring_next(ring_next(RING_RST));
      bus_byte_q <= 1'b0;
      bus_hi_q   <= 1'b0;
    end else begin
      if (int_req_i && !int_we_i) int_rd_q <= int_map;
      if (cmp_req_i && !cmp_we_i) cmp_rd_q <= cmp_map;
      if (bus_req_i && !bus_we_i) begin
        fill_rd_q  <= fill_map;
        bus_byte_q <= bus_byte_i;
        bus_hi_q   <= bus_hi_i;
      end
    end
  end

  always_comb begin
    int_rdata_o = '0;
    cmp_rdata_o = '0;
    bus_word    = '0;
    for (int b = 0; b < RING_W; b++) begin
      if (int_rd_q[b])  int_rdata_o = int_rdata_o | bank_q[b];
      if (cmp_rd_q[b])  cmp_rdata_o = cmp_rdata_o | bank_q[b];
      if (fill_rd_q[b]) bus_word    = bus_word | bank_q[b];
    end
  end

  assign ring_o = ring;
endmodule

// File: rtl/seg_ring_buffer_chk.sv
module seg_ring_buffer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ring_load_i,
  input logic [2:0] ring_val_i,
  input logic       seg_done_i,
  input logic       irq_ack_i,
  input logic [2:0] ring_o,
  input logic       refill_irq_o,
  input logic       overrun_o
);
  assert_ring_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(ring_o));

  assert_rotate_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_done_i && !ring_load_i) |=> (ring_o == {$past(ring_o[1:0]), $past(ring_o[2])}));

  assert_irq_on_rotate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_done_i && !ring_load_i) |=> refill_irq_o);

  assert_irq_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_irq_o && !irq_ack_i) |=> refill_irq_o);

  assert_overrun_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_done_i && !ring_load_i && refill_irq_o && !irq_ack_i) |=> overrun_o);

  assert_load_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_load_i && $onehot(ring_val_i)) |=> (ring_o == $past(ring_val_i)));

  assert_illegal_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_load_i && !$onehot(ring_val_i)) |=> (ring_o == 3'b001));
endmodule

bind seg_ring_buffer seg_ring_buffer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ring_load_i  (ring_load_i),
  .ring_val_i   (ring_val_i),
  .seg_done_i   (seg_done_i),
  .irq_ack_i    (irq_ack_i),
  .ring_o       (ring_o),
  .refill_irq_o (refill_irq_o),
  .overrun_o    (overrun_o)
);

// File: tb/seg_ring_buffer_test.sv
`timescale 1ns/1ps
module seg_ring_buffer_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        int_req = 0, int_we = 0, cmp_req = 0, cmp_we = 0;
  logic        bus_req = 0, bus_we = 0, bus_byte = 0, bus_hi = 0;
  logic [7:0]  int_addr = 0, cmp_addr = 0, bus_addr = 0;
  logic [15:0] int_wdata = 0, cmp_wdata = 0, bus_wdata = 0;
  logic [15:0] int_rdata, cmp_rdata, bus_rdata;
  logic        ring_load = 0, seg_done = 0, irq_ack = 0;
  logic [2:0]  ring_val = 0, ring;
  logic        irq, ovr;

  int checks = 0, failures = 0, cycles = 0;

  typedef struct { int port; logic [15:0] val; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  seg_ring_buffer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .int_req_i(int_req), .int_we_i(int_we), .int_addr_i(int_addr),
    .int_wdata_i(int_wdata), .int_rdata_o(int_rdata),
    .cmp_req_i(cmp_req), .cmp_we_i(cmp_we), .cmp_addr_i(cmp_addr),
    .cmp_wdata_i(cmp_wdata), .cmp_rdata_o(cmp_rdata),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_byte_i(bus_byte), .bus_hi_i(bus_hi),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .ring_load_i(ring_load), .ring_val_i(ring_val), .seg_done_i(seg_done),
    .irq_ack_i(irq_ack), .ring_o(ring), .refill_irq_o(irq), .overrun_o(ovr)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per read issued at an edge
  initial begin
    forever begin
      @(posedge clk);
      if ((int_req && !int_we) || (cmp_req && !cmp_we) || (bus_req && !bus_we)) begin
        exp_t e;
        @(negedge clk);
        e = sb.pop_front();
        case (e.port)
          0: check(e.tag, int_rdata, e.val);
          1: check(e.tag, cmp_rdata, e.val);
          default: check(e.tag, bus_rdata, e.val);
        endcase
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic end_cycle();
    @(posedge clk); #1;
    int_req = 0; cmp_req = 0; bus_req = 0;
    ring_load = 0; seg_done = 0; irq_ack = 0;
  endtask

  task automatic wr(input int port, input logic [7:0] a, input logic [15:0] d,
                    input logic bt = 0, input logic hi = 0);
    @(negedge clk);
    case (port)
      0: begin int_req = 1; int_we = 1; int_addr = a; int_wdata = d; end
      1: begin cmp_req = 1; cmp_we = 1; cmp_addr = a; cmp_wdata = d; end
      default: begin bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
                     bus_byte = bt; bus_hi = hi; end
    endcase
    end_cycle();
  endtask

  task automatic rd(input int port, input logic [7:0] a, input logic [15:0] ev,
                    input string tag, input logic bt = 0, input logic hi = 0);
    exp_t e;
    @(negedge clk);
    e.port = port; e.val = ev; e.tag = tag;
    sb.push_back(e);
    case (port)
      0: begin int_req = 1; int_we = 0; int_addr = a; end
      1: begin cmp_req = 1; cmp_we = 0; cmp_addr = a; end
      default: begin bus_req = 1; bus_we = 0; bus_addr = a; bus_byte = bt; bus_hi = hi; end
    endcase
    end_cycle();
  endtask

  task automatic ctrl(input logic ld, input logic [2:0] v, input logic done, input logic ack);
    @(negedge clk);
    ring_load = ld; ring_val = v; seg_done = done; irq_ack = ack;
    end_cycle();
    @(negedge clk);
  endtask

  task automatic chk_state(input string tag, input logic [2:0] r, input logic i, input logic o);
    check({tag, " ring"}, {13'b0, ring}, {13'b0, r});
    check({tag, " irq"}, {15'b0, irq}, {15'b0, i});
    check({tag, " overrun"}, {15'b0, ovr}, {15'b0, o});
  endtask

  initial begin
    #20; rst_n = 1;
    @(negedge clk);
    chk_state("R1 reset", 3'b001, 0, 0);

    // ring 001: int=bank0, cmp=bank1, refill=bank2
    wr(2, 8'd5, 16'hA5A5);
    wr(2, 8'd255, 16'h1234);
    wr(0, 8'd5, 16'h1111);
    wr(1, 8'd5, 16'h2222);
    rd(0, 8'd5, 16'h1111, "R2 R3 int port own bank");
    rd(1, 8'd5, 16'h2222, "R2 R3 cmp port own bank");
    rd(2, 8'd5, 16'hA5A5, "R2 R3 bus port refill bank");
    rd(2, 8'd255, 16'h1234, "R3 top address");

    // byte transfers, high byte swapped onto low lanes
    wr(2, 8'd7, 16'hFF34, 1, 0);
    wr(2, 8'd7, 16'hEE12, 1, 1);
    rd(2, 8'd7, 16'h1234, "R9 two byte writes form word");
    rd(2, 8'd7, 16'h0012, "R10 high byte on low lanes", 1, 1);
    rd(2, 8'd7, 16'h0034, "R10 low byte", 1, 0);
    wr(2, 8'd7, 16'h00CD, 1, 0);
    rd(2, 8'd7, 16'h12CD, "R9 low byte rewrite keeps high");

    // rotation 1: int=bank1, cmp=bank2, refill=bank0
    ctrl(0, 3'b000, 1, 0);
    chk_state("R4 R5 first rotation", 3'b010, 1, 0);
    repeat (3) @(negedge clk);
    check("R5 irq held", {15'b0, irq}, 16'h0001);
    rd(0, 8'd5, 16'h2222, "R11 cmp data now on int");
    rd(1, 8'd5, 16'hA5A5, "R11 refill data now on cmp");
    rd(2, 8'd5, 16'h1111, "R2 old int bank now refill");

    // rotation 2 without ack: overrun
    ctrl(0, 3'b000, 1, 0);
    chk_state("R6 overrun", 3'b100, 1, 1);
    rd(0, 8'd5, 16'hA5A5, "R11 loaded word reaches int");
    rd(0, 8'd7, 16'h12CD, "R11 byte-built word reaches int");

    ctrl(0, 3'b000, 0, 1);
    chk_state("R5 R6 ack clears", 3'b100, 0, 0);

    ctrl(0, 3'b000, 1, 0);
    chk_state("R4 wrap", 3'b001, 1, 0);
    ctrl(0, 3'b000, 1, 1);
    chk_state("R5 rotate with ack keeps irq", 3'b010, 1, 0);

    ctrl(0, 3'b000, 0, 1);
    ctrl(1, 3'b100, 1, 0);
    chk_state("R7 load beats rotate", 3'b100, 0, 0);
    ctrl(1, 3'b010, 0, 0);
    chk_state("R7 load one-hot", 3'b010, 0, 0);
    ctrl(1, 3'b011, 0, 0);
    chk_state("R8 illegal 011", 3'b001, 0, 0);
    ctrl(1, 3'b010, 0, 0);
    ctrl(1, 3'b000, 0, 0);
    chk_state("R8 illegal 000", 3'b001, 0, 0);

    repeat (4) @(negedge clk);
    check("scoreboard drained", 16'(sb.size()), 16'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule